// File: doc/BRIEF.md
# Multi-Source A20 Gate Combiner

This block merges every control that can let CPU address bit 20 through onto a single gate, then applies that gate to the CPU address. Three sources feed the gate: the A20 bit of the keyboard controller's output port, the A20 bit of the system control port, and an internal force flag. The gate is open whenever at least one of these sources asks for it. When the gate is closed, the block clears bit 20 of the outgoing address. Every other address bit passes straight through without a register.

The force flag is driven by two dummy I/O accesses to a small port pair. A read of the force port returns all ones and raises the flag. Any write to the force port lowers the flag, whatever the data. Any write to the companion reset port launches a fast CPU reset pulse. The system control port's own reset request launches the same pulse, and both share one length parameter. The port pair answers only while an enable input is high.

A typical use is to sit between the CPU address bus and the memory decoder, with the I/O decoder's strobes wired to the port inputs.

Top module: `a20_gate_combiner`

## Requirements
- R1: `a20_gate_o` is high in the same cycle as `kbc_a20_i` or `p92_a20_i` is high, or whenever the force flag is set; otherwise it is low.
- R2: `cpu_addr_o` equals `cpu_addr_i` with bit 20 ANDed with `a20_gate_o`, in the same cycle. For example, 0xFFFFFFF0 becomes 0xFFEFFFF0 while the gate is closed.
- R3: With `dummy_en_i` high, a read (`io_rd_i`) of address 0x00EE has these effects. In that cycle `io_claim_o` is high and `io_rdata_o` is 0xFF. From the next cycle on, the force flag is set.
- R4: With `dummy_en_i` high, a write (`io_wr_i`) to 0x00EE has these effects. In that cycle `io_claim_o` is high and `io_rdata_o` is 0x00. From the next cycle on, the force flag is clear.
- R5: With `dummy_en_i` high, a write to 0x00EF in cycle N has these effects. In cycle N `io_claim_o` is high. `cpu_rst_o` is high in cycles N+1 through N+RST_CYCLES and low in cycle N+RST_CYCLES+1.
- R6: `p92_rst_req_i` high in cycle N produces the same `cpu_rst_o` pulse as R5.
- R7: While `dummy_en_i` is low, accesses to 0x00EE and 0x00EF have no effect. `io_claim_o` stays low, `io_rdata_o` stays 0x00, the force flag keeps its value and no reset pulse starts.
- R8: After reset the force flag is clear and `cpu_rst_o` is low.
- R9: A read and a write of 0x00EE in the same enabled cycle leave the force flag clear.
- R10: A new reset request during a pulse restarts the count. `cpu_rst_o` then stays high through RST_CYCLES cycles after the last request.
- R11: A read of 0x00EF is not claimed. `io_claim_o` is low and `io_rdata_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbc_a20_i | input | 1 | A20 request from keyboard controller output port |
| p92_a20_i | input | 1 | A20 request from system control port |
| p92_rst_req_i | input | 1 | Fast reset request from system control port |
| dummy_en_i | input | 1 | Enables the force/reset port pair |
| io_addr_i | input | IO_AW (16) | I/O address |
| io_rd_i | input | 1 | I/O read strobe |
| io_wr_i | input | 1 | I/O write strobe |
| io_rdata_o | output | 8 | Read data for a claimed read |
| io_claim_o | output | 1 | Block responds to this I/O access |
| cpu_addr_i | input | ADDR_W (32) | CPU address |
| cpu_addr_o | output | ADDR_W (32) | Gated address |
| a20_gate_o | output | 1 | Combined A20 gate |
| cpu_rst_o | output | 1 | Fast CPU reset pulse |

## Verification
The gate is driven in turn by each source on its own, by sources together, and by none. This separates a correct OR from an AND or from a missing input. Addresses are applied with bit 20 set and with it clear, alongside neighbouring set bits. This shows that only bit 20 is masked and that the mask follows the gate in the same cycle. The port accesses are repeated with the enable low, with read and write at once, and as reads of the reset port. These cases expose decode that ignores the enable, or that lets the wrong access win. Reset pulses are started from both sources and retriggered mid-pulse, so an off-by-one length or a missing reload shows at the pulse edges.

// File: rtl/a20_pkg.sv
package a20_pkg;

    typedef struct packed {
        logic force_rd;
        logic force_wr;
        logic reset_wr;
    } io_hit_t;

    typedef struct packed {
        logic flag;
    } force_st_t;

endpackage

// File: rtl/a20_port_decode.sv
module a20_port_decode
    import a20_pkg::*;
#(
    parameter int          IO_AW      = 16,
    parameter logic [15:0] FORCE_PORT = 16'h00EE,
    parameter logic [15:0] RESET_PORT = 16'h00EF
) (
    input  logic             en_i,
    input  logic [IO_AW-1:0] addr_i,
    input  logic             rd_i,
    input  logic             wr_i,
    output io_hit_t          hit_o
);

    localparam logic [IO_AW-1:0] FORCE_A = IO_AW'(FORCE_PORT);
    localparam logic [IO_AW-1:0] RESET_A = IO_AW'(RESET_PORT);

    always_comb begin
        hit_o          = '0;
        hit_o.force_rd = en_i && rd_i && (addr_i == FORCE_A);
        hit_o.force_wr = en_i && wr_i && (addr_i == FORCE_A);
        hit_o.reset_wr = en_i && wr_i && (addr_i == RESET_A);
    end

endmodule

// File: rtl/a20_force_flag.sv
module a20_force_flag
    import a20_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  io_hit_t hit_i,
    output logic    flag_o
);

    force_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit_i.force_wr) begin
            st_d.flag = 1'b0;          // write wins over a same-cycle read
        end else if (hit_i.force_rd) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    a_r3_read_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i.force_rd && !hit_i.force_wr) |=> flag_o);

    a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i.force_wr |=> !flag_o);

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_i.force_wr && !hit_i.force_rd) |=> $stable(flag_o));

endmodule

// File: rtl/a20_reset_pulse.sv
module a20_reset_pulse #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pulse_o
);

    localparam int CW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_i) begin
            st_d.cnt = CW'(RST_CYCLES);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = (st_q.cnt != '0);

    a_r5_req_starts: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> pulse_o);

    a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(RST_CYCLES));

endmodule

// File: rtl/a20_gate_combiner.sv
module a20_gate_combiner
    import a20_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          GATE_BIT   = 20,
    parameter int          IO_AW      = 16,
    parameter logic [15:0] FORCE_PORT = 16'h00EE,
    parameter logic [15:0] RESET_PORT = 16'h00EF,
    parameter int          RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbc_a20_i,
    input  logic              p92_a20_i,
    input  logic              p92_rst_req_i,
    input  logic              dummy_en_i,
    input  logic [IO_AW-1:0]  io_addr_i,
    input  logic              io_rd_i,
    input  logic              io_wr_i,
    output logic [7:0]        io_rdata_o,
    output logic              io_claim_o,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    output logic [ADDR_W-1:0] cpu_addr_o,
    output logic              a20_gate_o,
    output logic              cpu_rst_o
);

    localparam logic [ADDR_W-1:0] KEEP_MASK = ~(ADDR_W'(1) << GATE_BIT);

    io_hit_t hit;
    logic    force_flag;

    a20_port_decode #(
        .IO_AW      (IO_AW),
        .FORCE_PORT (FORCE_PORT),
        .RESET_PORT (RESET_PORT)
    ) u_dec (
        .en_i   (dummy_en_i),
        .addr_i (io_addr_i),
        .rd_i   (io_rd_i),
        .wr_i   (io_wr_i),
        .hit_o  (hit)
    );

    a20_force_flag u_force (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit),
        .flag_o (force_flag)
    );

    a20_reset_pulse #(
        .RST_CYCLES (RST_CYCLES)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (hit.reset_wr || p92_rst_req_i),
        .pulse_o (cpu_rst_o)
    );

    always_comb begin
        a20_gate_o = kbc_a20_i || p92_a20_i || force_flag;
        cpu_addr_o = a20_gate_o ? cpu_addr_i : (cpu_addr_i & KEEP_MASK);
        io_claim_o = hit.force_rd || hit.force_wr || hit.reset_wr;
        io_rdata_o = hit.force_rd ? 8'hFF : 8'h00;
    end

    a_r1_kbc_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (kbc_a20_i || p92_a20_i) |-> (cpu_addr_o[GATE_BIT] == cpu_addr_i[GATE_BIT]));

    a_r2_closed_masks: assert property (@(posedge clk) disable iff (!rst_n)
        !a20_gate_o |-> ((cpu_addr_o[GATE_BIT] == 1'b0)
                         && ((cpu_addr_o & KEEP_MASK) == (cpu_addr_i & KEEP_MASK))));

    a_r7_disabled_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (!dummy_en_i && !p92_rst_req_i && !cpu_rst_o) |=> ($stable(force_flag) && !cpu_rst_o));

    a_r8_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!force_flag && !cpu_rst_o));

endmodule

// File: tb/sim_a20_gate_combiner.sv
module sim_a20_gate_combiner;

    localparam int RST = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kbc = 1'b0, p92 = 1'b0, p92rst = 1'b0, en = 1'b0;
    logic [15:0] ioa = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  rdata;
    logic        claim;
    logic [31:0] ain = '0, aout;
    logic        gate, crst;

    always #5 clk = ~clk;

    a20_gate_combiner #(.RST_CYCLES(RST)) u0 (
        .clk(clk), .rst_n(rst_n), .kbc_a20_i(kbc), .p92_a20_i(p92),
        .p92_rst_req_i(p92rst), .dummy_en_i(en), .io_addr_i(ioa),
        .io_rd_i(rd), .io_wr_i(wr), .io_rdata_o(rdata), .io_claim_o(claim),
        .cpu_addr_i(ain), .cpu_addr_o(aout), .a20_gate_o(gate), .cpu_rst_o(crst)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          at;
        int          sig;   // 0 addr, 1 gate, 2 reset, 3 rdata, 4 claim
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int n_cmp = 0;
    int n_bad = 0;

    function automatic logic [31:0] observe(int sig);
        case (sig)
            0: return aout;
            1: return {31'd0, gate};
            2: return {31'd0, crst};
            3: return {24'd0, rdata};
            default: return {31'd0, claim};
        endcase
    endfunction

    task automatic expect_at(int at, int sig, logic [31:0] e, string req);
        item_t it;
        it.at = at; it.sig = sig; it.exp = e; it.req = req;
        sb.push_back(it);
    endtask

    // monitor: compares scoreboard items due in this cycle, away from the edge
    always @(negedge clk) begin
        int i;
        i = 0;
        while (i < sb.size()) begin
            if (sb[i].at == cyc) begin
                logic [31:0] got;
                got = observe(sb[i].sig);
                n_cmp++;
                if (got !== sb[i].exp) begin
                    n_bad++;
                    $display("FAIL %s sig%0d cycle %0d: actual %h expected %h",
                             sb[i].req, sb[i].sig, cyc, got, sb[i].exp);
                end
                sb.delete(i);
            end else begin
                i++;
            end
        end
    end

    task automatic step(logic k, logic p, logic pr, logic e, logic [15:0] a,
                        logic r, logic w, logic [31:0] ca);
        @(posedge clk);
        #1;
        kbc = k; p92 = p; p92rst = pr; en = e; ioa = a; rd = r; wr = w; ain = ca;
    endtask

    task automatic idle(int n, logic e);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, e, 16'h0000, 1'b0, 1'b0, 32'h0);
    endtask

    // pulse expectations for a request in cycle c
    task automatic expect_pulse(int c, string req);
        for (int k = 1; k <= RST; k++) expect_at(c + k, 2, 32'd1, req);
        expect_at(c + RST + 1, 2, 32'd0, req);
    endtask

    bit timeout = 1'b0;

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1 rst_n = 1'b1;
                ain = 32'hFFFFFFF0;
                // R8 / R2: reset state and masked reset fetch address
                expect_at(cyc, 1, 32'd0, "R8");
                expect_at(cyc, 2, 32'd0, "R8");
                expect_at(cyc, 0, 32'hFFEFFFF0, "R2");

                // R1 / R2: each source alone, both, none
                step(1, 0, 0, 0, 16'h0, 0, 0, 32'h7FF12345);
                expect_at(cyc, 1, 32'd1, "R1"); expect_at(cyc, 0, 32'h7FF12345, "R2");
                step(0, 1, 0, 0, 16'h0, 0, 0, 32'h00100000);
                expect_at(cyc, 1, 32'd1, "R1"); expect_at(cyc, 0, 32'h00100000, "R2");
                step(1, 1, 0, 0, 16'h0, 0, 0, 32'hFFFFFFFF);
                expect_at(cyc, 0, 32'hFFFFFFFF, "R1");
                step(0, 0, 0, 0, 16'h0, 0, 0, 32'h7FF12345);
                expect_at(cyc, 1, 32'd0, "R1"); expect_at(cyc, 0, 32'h7FE12345, "R2");
                step(0, 0, 0, 0, 16'h0, 0, 0, 32'hABCDEF01);
                expect_at(cyc, 0, 32'hABCDEF01, "R2");

                // R3: dummy read sets force
                step(0, 0, 0, 1, 16'h00EE, 1, 0, 32'h00100000);
                expect_at(cyc, 4, 32'd1, "R3"); expect_at(cyc, 3, 32'hFF, "R3");
                expect_at(cyc, 0, 32'h0, "R3");
                step(0, 0, 0, 1, 16'h0, 0, 0, 32'h00100000);
                expect_at(cyc, 1, 32'd1, "R3"); expect_at(cyc, 0, 32'h00100000, "R3");

                // R4: write clears
                step(0, 0, 0, 1, 16'h00EE, 0, 1, 32'h00100000);
                expect_at(cyc, 4, 32'd1, "R4"); expect_at(cyc, 3, 32'h00, "R4");
                step(0, 0, 0, 1, 16'h0, 0, 0, 32'h00100000);
                expect_at(cyc, 1, 32'd0, "R4"); expect_at(cyc, 0, 32'h0, "R4");

                // R9: set then read+write together
                step(0, 0, 0, 1, 16'h00EE, 1, 0, 32'h0);
                step(0, 0, 0, 1, 16'h00EE, 1, 1, 32'h0);
                expect_at(cyc, 1, 32'd1, "R9");
                step(0, 0, 0, 1, 16'h0, 0, 0, 32'h0);
                expect_at(cyc, 1, 32'd0, "R9");

                // R7: disabled read does not set
                step(0, 0, 0, 0, 16'h00EE, 1, 0, 32'h0);
                expect_at(cyc, 4, 32'd0, "R7"); expect_at(cyc, 3, 32'h00, "R7");
                step(0, 0, 0, 0, 16'h0, 0, 0, 32'h0);
                expect_at(cyc, 1, 32'd0, "R7");
                // R7: set with enable, then disabled write does not clear
                step(0, 0, 0, 1, 16'h00EE, 1, 0, 32'h0);
                step(0, 0, 0, 0, 16'h00EE, 0, 1, 32'h0);
                expect_at(cyc, 4, 32'd0, "R7");
                step(0, 0, 0, 0, 16'h0, 0, 0, 32'h0);
                expect_at(cyc, 1, 32'd1, "R7");
                // R7: disabled reset write starts nothing
                step(0, 0, 0, 0, 16'h00EF, 0, 1, 32'h0);
                expect_at(cyc, 4, 32'd0, "R7");
                for (int k = 1; k <= RST + 1; k++) expect_at(cyc + k, 2, 32'd0, "R7");
                idle(RST + 2, 1'b0);
                // clear the force flag again
                step(0, 0, 0, 1, 16'h00EE, 0, 1, 32'h0);

                // R11: read of reset port not claimed
                step(0, 0, 0, 1, 16'h00EF, 1, 0, 32'h0);
                expect_at(cyc, 4, 32'd0, "R11"); expect_at(cyc, 3, 32'h00, "R11");
                expect_at(cyc + 1, 2, 32'd0, "R11");

                // R5: reset port write pulse
                step(0, 0, 0, 1, 16'h00EF, 0, 1, 32'h0);
                expect_at(cyc, 4, 32'd1, "R5");
                expect_pulse(cyc, "R5");
                idle(RST + 2, 1'b1);

                // R6: system control port reset request
                step(0, 0, 1, 0, 16'h0, 0, 0, 32'h0);
                expect_pulse(cyc, "R6");
                idle(RST + 2, 1'b0);

                // R10: retrigger two cycles into the pulse
                step(0, 0, 1, 0, 16'h0, 0, 0, 32'h0);
                expect_at(cyc + 1, 2, 32'd1, "R10");
                idle(1, 1'b0);
                step(0, 0, 1, 0, 16'h0, 0, 0, 32'h0);
                expect_pulse(cyc, "R10");
                idle(RST + 3, 1'b0);
                wait (sb.size() == 0);
            end
            begin
                repeat (20000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        if (timeout) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        foreach (sb[i]) begin
            n_bad++;
            $display("FAIL %s never compared: actual none expected %h", sb[i].req, sb[i].exp);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule